// File: doc/BRIEF.md
# Saturating Arithmetic Unit

A single-cycle registered datapath for 32-bit saturating arithmetic. Each clock edge it takes two operands, a 5-bit saturation position and a 4-bit operation code, and registers a 32-bit result. The operations cover signed and unsigned clamped add and subtract, signed clamped doubling, saturation of a word to a programmable bit position (signed or unsigned), the same saturation applied independently to both 16-bit halves, and a plain wrapping add that still reports signed overflow.

A sticky saturation flag records that some clamping event has occurred since it was last cleared. Arithmetic never lowers the flag. Only reset or a clear pulse lowers it, and a clamping event in the same cycle as a clear pulse wins. The unit computes a new result every cycle, so the surrounding logic presents a harmless operation (for example 0 + 0 with code 0) when idle.

Top module: `sat_alu`

## Requirements
- R1: While rst_n is low and on the first edge after it, result is 0 and sat_flag is 0.
- R2: Code 0 (signed add): if both operands share a sign and the 32-bit sum's sign differs, the result is 0x7FFFFFFF when op_a is non-negative and 0x80000000 when negative, and this is a clamping event; otherwise the wrapped sum.
- R3: Code 1 (signed subtract op_a - op_b): if the operand signs differ and the difference's sign differs from op_a, it clamps as in R2 and this is a clamping event; otherwise the wrapped difference.
- R4: Code 2 (signed doubling of op_a): op_a >= 0x40000000 gives 0x7FFFFFFF, op_a <= 0xC0000000 (signed) gives 0x80000000, both clamping events; otherwise op_a shifted left by one.
- R5: Code 3 (unsigned add) gives 0xFFFFFFFF when the sum exceeds 32 bits; code 4 (unsigned subtract) gives 0 when op_b > op_a; each such case is a clamping event.
- R6: Code 5 (signed saturate op_a to position n = sat_pos): values above 2^n-1 give 2^n-1, values below -2^n give -2^n (both clamping events); others pass through.
- R7: Code 6 (unsigned saturate op_a to position n): negative values give 0, values above 2^n-1 give 2^n-1 (both clamping events); others pass through.
- R8: Codes 7 and 8 apply R6 and R7 respectively to the sign-extended bits [15:0] and [31:16] of op_a independently, placing the low 16 bits of each result in the same half; a clamp in either half is a clamping event.
- R9: Code 9 returns the wrapped sum op_a + op_b and raises a clamping event under the signed overflow condition of R2.
- R10: sat_flag is 1 after an edge with a clamping event; otherwise it keeps its value unless q_clear was high at that edge, in which case it becomes 0.
- R11: Each result appears one clock edge after its inputs; codes 10 to 15 give result 0 and no clamping event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Operation code (see R2 to R11) |
| op_a | input | 32 | First operand, and the value to saturate or double |
| op_b | input | 32 | Second operand for add and subtract |
| sat_pos | input | 5 | Saturation bit position n |
| q_clear | input | 1 | Clears the sticky flag at the edge |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Both result and sat_flag are registered, so an operation driven before a rising edge shows its effect just after that edge. The bench changes inputs at the falling edge and samples one nanosecond after the next rising edge, once per operation. The flag is checked against a bench model that carries its value from one operation to the next, so clear pulses, set-wins and stickiness are checked in every step of the sweeps.

// File: rtl/sat_alu_pkg.sv
// Package: operation codes shared by the saturating unit and its checker.
package sat_alu_pkg;
    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_SDBL   = 4'd2,
        OP_UADD   = 4'd3,
        OP_USUB   = 4'd4,
        OP_SSATW  = 4'd5,
        OP_USATW  = 4'd6,
        OP_SSATH  = 4'd7,
        OP_USATH  = 4'd8,
        OP_ADDFLG = 4'd9
    } sat_op_t;
endpackage

// File: rtl/sat_addsub.sv
// Clamped add/subtract/doubling datapath.
// Purely combinational; assumes W >= 3. Reports a clamping event on hit.
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  sat_op_t      op,
    output logic [W-1:0] res,
    output logic         hit
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;
    logic [W-1:0] clamp_a;
    logic         add_ov, sub_ov, dbl_hi, dbl_lo;

    // Overflow detection for the signed and unsigned forms.
    always_comb begin
        sum_x   = {1'b0, a} + {1'b0, b};
        dif_x   = {1'b0, a} - {1'b0, b};
        clamp_a = a[W-1] ? S_MIN : S_MAX;
        add_ov  = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
        sub_ov  = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
        dbl_hi  = !a[W-1] && a[W-2];
        dbl_lo  = a[W-1] && (!a[W-2] || (a[W-3:0] == '0));
    end

    // Result and event selection by operation.
    always_comb begin
        res = '0;
        hit = 1'b0;
        case (op)
            OP_SADD: begin
                res = add_ov ? clamp_a : sum_x[W-1:0];
                hit = add_ov;
            end
            OP_SSUB: begin
                res = sub_ov ? clamp_a : dif_x[W-1:0];
                hit = sub_ov;
            end
            OP_SDBL: begin
                res = dbl_hi ? S_MAX : (dbl_lo ? S_MIN : {a[W-2:0], 1'b0});
                hit = dbl_hi || dbl_lo;
            end
            OP_UADD: begin
                res = sum_x[W] ? '1 : sum_x[W-1:0];
                hit = sum_x[W];
            end
            OP_USUB: begin
                res = dif_x[W] ? '0 : dif_x[W-1:0];
                hit = dif_x[W];
            end
            OP_ADDFLG: begin
                res = sum_x[W-1:0];
                hit = add_ov;
            end
            default: begin
                res = '0;
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
// Saturates a signed W-bit value to bit position pos, signed or unsigned.
// Combinational; returns the low OUT_W bits of the clamped value.
module sat_clamp #(
    parameter int W     = 32,
    parameter int PW    = 5,
    parameter int OUT_W = 32
) (
    input  logic [W-1:0]     val,
    input  logic [PW-1:0]    pos,
    input  logic             uns,
    output logic [OUT_W-1:0] res,
    output logic             hit
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] mask;
    logic [W-1:0] top;
    logic         top_pos, top_neg, u_big;

    // Limit mask and the value above the saturation position.
    always_comb begin
        mask    = (ONE << pos) - ONE;
        top     = W'($signed(val) >>> pos);
        top_pos = !top[W-1] && (top != '0);
        top_neg = top[W-1] && (top != '1);
        u_big   = !val[W-1] && (val > mask);
    end

    // Clamp selection.
    always_comb begin
        if (uns) begin
            res = val[W-1] ? '0 : (u_big ? mask[OUT_W-1:0] : val[OUT_W-1:0]);
            hit = val[W-1] || u_big;
        end else begin
            res = top_pos ? mask[OUT_W-1:0]
                          : (top_neg ? ~mask[OUT_W-1:0] : val[OUT_W-1:0]);
            hit = top_pos || top_neg;
        end
    end
endmodule

// File: rtl/sat_alu.sv
// Saturating arithmetic unit, top level.
// Registers the selected result and a sticky saturation flag each edge.
// Assumes synchronous active-low reset; inputs are valid every cycle.
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  opcode,
    input  logic [DATA_W-1:0]           op_a,
    input  logic [DATA_W-1:0]           op_b,
    input  logic [$clog2(DATA_W)-1:0]   sat_pos,
    input  logic                        q_clear,
    output logic [DATA_W-1:0]           result,
    output logic                        sat_flag
);
    localparam int POS_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;
    localparam int NHALF  = 2;

    sat_op_t              op;
    logic [DATA_W-1:0]    as_res;
    logic                 as_hit;
    logic [DATA_W-1:0]    wd_res;
    logic                 wd_hit;
    logic [HALF_W-1:0]    hf_res [NHALF];
    logic [NHALF-1:0]     hf_hit;
    logic                 uns_sel;
    logic [DATA_W-1:0]    nxt_res;
    logic                 nxt_hit;

    assign op      = sat_op_t'(opcode);
    assign uns_sel = (op == OP_USATW) || (op == OP_USATH);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a(op_a), .b(op_b), .op(op), .res(as_res), .hit(as_hit)
    );

    sat_clamp #(.W(DATA_W), .PW(POS_W), .OUT_W(DATA_W)) u_word (
        .val(op_a), .pos(sat_pos), .uns(uns_sel), .res(wd_res), .hit(wd_hit)
    );

    // One clamp per halfword lane on the sign-extended half.
    for (genvar g = 0; g < NHALF; g++) begin : g_half
        logic [DATA_W-1:0] ext;
        assign ext = {{(DATA_W-HALF_W){op_a[g*HALF_W+HALF_W-1]}},
                      op_a[g*HALF_W +: HALF_W]};
        sat_clamp #(.W(DATA_W), .PW(POS_W), .OUT_W(HALF_W)) u_hclamp (
            .val(ext), .pos(sat_pos), .uns(uns_sel),
            .res(hf_res[g]), .hit(hf_hit[g])
        );
    end

    // Pick the unit that serves the current operation.
    always_comb begin
        case (op)
            OP_SSATW, OP_USATW: begin
                nxt_res = wd_res;
                nxt_hit = wd_hit;
            end
            OP_SSATH, OP_USATH: begin
                nxt_res = {hf_res[1], hf_res[0]};
                nxt_hit = |hf_hit;
            end
            default: begin
                nxt_res = as_res;
                nxt_hit = as_hit;
            end
        endcase
    end

    // Result register and sticky flag; a new event outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            sat_flag <= 1'b0;
        end else begin
            result   <= nxt_res;
            sat_flag <= nxt_hit || (sat_flag && !q_clear);
        end
    end
endmodule

// File: rtl/sat_alu_chk.sv
// Checker for sat_alu: relates inputs at one edge to outputs after it.
module sat_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  opcode,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [4:0]  sat_pos,
    input logic        q_clear,
    input logic [31:0] result,
    input logic        sat_flag
);
    // R10: flag only drops after a clear request
    p_flag_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_flag) |-> $past(q_clear));

    // R10: flag holds without a clear
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !q_clear) |=> sat_flag);

    // R5: unsigned add wrap clamps to all ones and sets the flag
    p_uadd_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd3 && ({1'b0, op_a} + {1'b0, op_b}) > 33'h0FFFFFFFF)
        |=> (result == 32'hFFFFFFFF && sat_flag));

    // R5: unsigned subtract borrow clamps to zero and sets the flag
    p_usub_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd4 && op_a < op_b) |=> (result == 32'd0 && sat_flag));

    // R2: signed add overflow lands on the extreme chosen by op_a's sign
    p_sadd_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd0 && op_a[31] == op_b[31] && ((op_a + op_b) >> 31) != {31'd0, op_a[31]})
        |=> (result == ($past(op_a[31]) ? 32'h80000000 : 32'h7FFFFFFF) && sat_flag));

    // R7: unsigned word saturation never exceeds the limit
    p_usat_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'd6) |=> (result <= ((32'd1 << $past(sat_pos)) - 32'd1)));

    // R11: unused codes give zero
    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode >= 4'd10) |=> (result == 32'd0));
endmodule

bind sat_alu sat_alu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
    .sat_pos(sat_pos), .q_clear(q_clear), .result(result), .sat_flag(sat_flag)
);

// File: tb/sat_alu_tb.sv
`timescale 1ns/1ps
module sat_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = 4'd0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [4:0]  sat_pos = '0;
    logic        q_clear = 1'b0;
    logic [31:0] result;
    logic        sat_flag;

    int  total = 0;
    int  bad   = 0;
    bit  model_q = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    sat_alu u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .sat_pos(sat_pos), .q_clear(q_clear), .result(result), .sat_flag(sat_flag)
    );

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic void sref(longint v, int n, bit uns,
                                 output logic [31:0] r, output bit e);
        longint hi, lo;
        hi = (64'sd1 <<< n) - 1;
        lo = -(64'sd1 <<< n);
        e = 1'b1;
        if (uns && v < 0)       r = 32'd0;
        else if (v > hi)        r = hi[31:0];
        else if (!uns && v < lo) r = lo[31:0];
        else begin
            r = v[31:0];
            e = 1'b0;
        end
    endfunction

    function automatic void ref_model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                      int n, output logic [31:0] r, output bit e);
        longint sa, sb, s, ua, ub;
        logic [31:0] r0, r1;
        bit e0, e1;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, b});
        e = 1'b0;
        r = 32'd0;
        case (op)
            4'd0, 4'd1, 4'd2, 4'd9: begin
                s = (op == 4'd0 || op == 4'd9) ? sa + sb : (op == 4'd1 ? sa - sb : 2 * sa);
                if (s > 64'sd2147483647) begin
                    r = 32'h7FFFFFFF; e = 1'b1;
                end else if (s < -64'sd2147483648 || (op == 4'd2 && s == -64'sd2147483648)) begin
                    r = 32'h80000000; e = 1'b1;
                end else r = s[31:0];
                if (op == 4'd9) r = a + b;
            end
            4'd3: begin
                s = ua + ub;
                if (s > 64'sd4294967295) begin r = 32'hFFFFFFFF; e = 1'b1; end
                else r = s[31:0];
            end
            4'd4: begin
                if (ua < ub) begin r = 32'd0; e = 1'b1; end
                else r = a - b;
            end
            4'd5, 4'd6: sref(sa, n, op == 4'd6, r, e);
            4'd7, 4'd8: begin
                sref(longint'($signed(a[15:0])), n, op == 4'd8, r0, e0);
                sref(longint'($signed(a[31:16])), n, op == 4'd8, r1, e1);
                r = {r1[15:0], r0[15:0]};
                e = e0 | e1;
            end
            default: begin r = 32'd0; e = 1'b0; end
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at falling edge, sample 1 ns after the next rising edge (R11 latency).
    task automatic step(logic [3:0] op, logic [31:0] a, logic [31:0] b, int n, bit clr);
        logic [31:0] er;
        bit ee;
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; sat_pos = n[4:0]; q_clear = clr;
        ref_model(op, a, b, n, er, ee);
        model_q = ee | (model_q & ~clr);
        @(posedge clk);
        #1;
        check(result == er, tag_of(op), result, er, "result");
        check(sat_flag == model_q, "R10", {31'd0, sat_flag}, {31'd0, model_q}, "flag");
    endtask

    logic [31:0] edges [14] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                                32'h40000000, 32'hC0000000, 32'h3FFFFFFF, 32'hC0000001,
                                32'h80000001, 32'h7FFFFFFE, 32'h00008000, 32'hFFFF7FFF,
                                32'h12345678};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(result == 32'd0, "R1", result, 32'd0, "result in reset");
        check(sat_flag == 1'b0, "R1", {31'd0, sat_flag}, 32'd0, "flag in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(result == 32'd0 && sat_flag == 1'b0, "R1", result, 32'd0, "first edge after reset");

        // R2 R3 R4 R5 R9: boundary pairs for add/sub style operations
        for (int op = 0; op < 5; op++)
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    step(op[3:0], edges[i], edges[j], 0, (i + j) % 3 == 0);
        for (int i = 0; i < 14; i++)
            for (int j = 0; j < 14; j++)
                step(4'd9, edges[i], edges[j], 0, j == 5);

        // R6 R7 R8: every position against boundary and halfword patterns
        for (int op = 5; op < 9; op++)
            for (int n = 0; n < 32; n++)
                for (int i = 0; i < 14; i++)
                    step(op[3:0], edges[i] ^ (32'h1 << n), 32'd0, n, i == 0);

        // R10: explicit sticky sequence
        step(4'd3, 32'hFFFFFFFF, 32'd1, 0, 1'b1);   // set
        step(4'd0, 32'd0, 32'd0, 0, 1'b0);          // holds
        step(4'd4, 32'd0, 32'd1, 0, 1'b1);          // set wins over clear
        step(4'd0, 32'd1, 32'd1, 0, 1'b1);          // clears
        step(4'd0, 32'd2, 32'd2, 0, 1'b0);          // stays clear

        // R11: unused codes
        for (int op = 10; op < 16; op++)
            step(op[3:0], 32'hFFFFFFFF, 32'h80000000, 31, 1'b0);

        // Random mix over all codes
        for (int k = 0; k < 3000; k++)
            step(4'($urandom_range(0, 15)), $urandom, $urandom,
                 int'($urandom_range(0, 31)), ($urandom & 7) == 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule